// File: doc/BRIEF.md
# Minimum-Counter Bucket Selector

This block holds a table of small per-bucket counters that together act as a counting Bloom filter for a hashed lookup structure. Every key handled by the surrounding datapath is presented as a set of candidate bucket indices. These indices are produced by an external hash stage, one per hash function. An insert raises the count of every distinct candidate bucket by one, and a delete lowers it by one. The counts therefore track how many stored keys map onto each bucket.

A query reads all candidate counters in the same cycle. If any candidate counter is zero, the key cannot be present, and the block reports a definite miss. Otherwise it names the candidate bucket with the lowest count, so that the least crowded list is searched. When counts are equal, the lowest bucket index wins. The answer is registered and appears one cycle after the query with a one-cycle valid strobe.

Top module: `cbf_min_select`

## Requirements
- R1: After reset every counter is zero and `res_valid` and `res_hit` are low.
- R2: An insert (`op_code` 2'b01) raises the counter of each distinct candidate bucket by one, and a delete (`op_code` 2'b10) lowers it by one. A bucket named more than once in one operation changes only once. Candidate j sits in `op_idx[j*IDX_W +: IDX_W]`.
- R3: On a query (`op_code` 2'b00) where every candidate count is non-zero, `res_hit` is high and `res_bucket` is the candidate with the smallest count. Among equal counts the smallest bucket index wins. `res_count` is that smallest count.
- R4: On a query where any candidate count is zero, `res_hit` is low and `res_bucket` and `res_count` are both zero.
- R5: A counter at its maximum (15 for 4-bit counters) stays at the maximum on both insert and delete.
- R6: A counter at zero stays at zero on delete. No counter moves by more than one per cycle.
- R7: `res_valid` is high for exactly the one cycle after a query is accepted. It stays low after insert, delete, reserved or idle cycles.
- R8: The reserved code 2'b11 changes no counter and produces no result.
- R9: A counter changed by an operation is seen by a query in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 2 | 00 query, 01 insert, 10 delete, 11 reserved |
| op_idx | input | NUM_HASH*IDX_W | Candidate bucket indices, candidate j at bits j*IDX_W |
| res_valid | output | 1 | Query result strobe |
| res_hit | output | 1 | All candidate counts non-zero |
| res_bucket | output | IDX_W | Selected bucket index, zero on a miss |
| res_count | output | CNT_W | Count of the selected bucket, zero on a miss |

## Verification
A query result is due on the first rising edge after the query is presented. Counter changes from an insert or delete are due on that same edge, so a query in the next cycle already sees them. The bench drives each operation on a falling edge and checks the outputs on the following falling edge. It computes the expected result from its own counter model as it stood before that operation, then applies the update to the model. For insert, delete and reserved codes it checks in that same slot that no strobe appeared, and it observes counter contents only through later single-bucket queries.

// File: rtl/cbf_pkg.sv
package cbf_pkg;
  typedef enum logic [1:0] {
    OP_QUERY  = 2'b00,
    OP_INSERT = 2'b01,
    OP_DELETE = 2'b10,
    OP_NOP    = 2'b11
  } cbf_op_e;
endpackage

// File: rtl/cbf_bucket_mask.sv
module cbf_bucket_mask #(
  parameter int NUM_BKT  = 64,
  parameter int NUM_HASH = 4,
  parameter int IDX_W    = $clog2(NUM_BKT)
) (
  input  logic [NUM_HASH*IDX_W-1:0] idx_flat,
  output logic [NUM_BKT-1:0]        mask
);
  // one bit per bucket: set when any candidate names it, so duplicates merge (R2)
  always_comb begin
    mask = '0;
    for (int b = 0; b < NUM_BKT; b++) begin
      for (int j = 0; j < NUM_HASH; j++) begin
        if (idx_flat[j*IDX_W +: IDX_W] == IDX_W'(b)) mask[b] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cbf_counter_bank.sv
module cbf_counter_bank #(
  parameter int NUM_BKT = 64,
  parameter int CNT_W   = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            inc_en,
  input  logic                            dec_en,
  input  logic [NUM_BKT-1:0]              mask,
  output logic [NUM_BKT-1:0][CNT_W-1:0]   cnt_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // saturating step: sticky at the top, floored at zero
  function automatic logic [CNT_W-1:0] step_cnt(
    input logic [CNT_W-1:0] cur,
    input logic             up,
    input logic             down
  );
    logic [CNT_W-1:0] nxt;
    nxt = cur;
    if (up && cur != CNT_MAX) nxt = cur + 1'b1;
    else if (down && cur != CNT_MAX && cur != '0) nxt = cur - 1'b1;
    return nxt;
  endfunction

  for (genvar b = 0; b < NUM_BKT; b++) begin : g_bkt
    always_ff @(posedge clk) begin
      if (!rst_n) cnt_q[b] <= '0;
      else        cnt_q[b] <= step_cnt(cnt_q[b], inc_en && mask[b], dec_en && mask[b]);
    end
  end
endmodule

// File: rtl/cbf_min_pick.sv
module cbf_min_pick #(
  parameter int NUM_HASH = 4,
  parameter int IDX_W    = 6,
  parameter int CNT_W    = 4
) (
  input  logic [NUM_HASH*IDX_W-1:0]       idx_flat,
  input  logic [NUM_HASH-1:0][CNT_W-1:0]  cand_cnt,
  output logic                            pick_hit,
  output logic [IDX_W-1:0]                pick_bucket,
  output logic [CNT_W-1:0]                pick_count
);
  // lower count first, then lower bucket index
  function automatic logic beats(
    input logic [CNT_W-1:0] ca, input logic [IDX_W-1:0] ia,
    input logic [CNT_W-1:0] cb, input logic [IDX_W-1:0] ib
  );
    return (ca < cb) || ((ca == cb) && (ia < ib));
  endfunction

  logic [CNT_W-1:0] best_c;
  logic [IDX_W-1:0] best_i;
  logic             any_zero;

  always_comb begin
    best_c   = cand_cnt[0];
    best_i   = idx_flat[0 +: IDX_W];
    any_zero = (cand_cnt[0] == '0);
    for (int j = 1; j < NUM_HASH; j++) begin
      if (cand_cnt[j] == '0) any_zero = 1'b1;
      if (beats(cand_cnt[j], idx_flat[j*IDX_W +: IDX_W], best_c, best_i)) begin
        best_c = cand_cnt[j];
        best_i = idx_flat[j*IDX_W +: IDX_W];
      end
    end
    pick_hit    = !any_zero;
    pick_bucket = any_zero ? '0 : best_i;
    pick_count  = any_zero ? '0 : best_c;
  end
endmodule

// File: rtl/cbf_min_select.sv
module cbf_min_select
  import cbf_pkg::*;
#(
  parameter int NUM_BKT  = 64,
  parameter int NUM_HASH = 4,
  parameter int CNT_W    = 4,
  localparam int IDX_W   = $clog2(NUM_BKT)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      op_valid,
  input  logic [1:0]                op_code,
  input  logic [NUM_HASH*IDX_W-1:0] op_idx,
  output logic                      res_valid,
  output logic                      res_hit,
  output logic [IDX_W-1:0]          res_bucket,
  output logic [CNT_W-1:0]          res_count
);
  cbf_op_e op;
  assign op = cbf_op_e'(op_code);

  // named events, also watched by the bound checker
  logic query_fire, upd_inc, upd_dec;
  assign query_fire = op_valid && (op == OP_QUERY);
  assign upd_inc    = op_valid && (op == OP_INSERT);
  assign upd_dec    = op_valid && (op == OP_DELETE);

  logic [NUM_BKT-1:0] hit_mask;
  cbf_bucket_mask #(.NUM_BKT(NUM_BKT), .NUM_HASH(NUM_HASH), .IDX_W(IDX_W)) u_mask (
    .idx_flat (op_idx),
    .mask     (hit_mask)
  );

  logic [NUM_BKT-1:0][CNT_W-1:0] cnt_q;
  cbf_counter_bank #(.NUM_BKT(NUM_BKT), .CNT_W(CNT_W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc_en (upd_inc),
    .dec_en (upd_dec),
    .mask   (hit_mask),
    .cnt_q  (cnt_q)
  );

  // k parallel read ports into the register array
  logic [NUM_HASH-1:0][CNT_W-1:0] cand_cnt;
  for (genvar j = 0; j < NUM_HASH; j++) begin : g_rd
    assign cand_cnt[j] = cnt_q[op_idx[j*IDX_W +: IDX_W]];
  end

  logic             pick_hit;
  logic [IDX_W-1:0] pick_bucket;
  logic [CNT_W-1:0] pick_count;
  cbf_min_pick #(.NUM_HASH(NUM_HASH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_pick (
    .idx_flat    (op_idx),
    .cand_cnt    (cand_cnt),
    .pick_hit    (pick_hit),
    .pick_bucket (pick_bucket),
    .pick_count  (pick_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_hit    <= 1'b0;
      res_bucket <= '0;
      res_count  <= '0;
    end else begin
      res_valid <= query_fire;
      if (query_fire) begin
        res_hit    <= pick_hit;
        res_bucket <= pick_bucket;
        res_count  <= pick_count;
      end
    end
  end
endmodule

// File: rtl/cbf_min_select_chk.sv
module cbf_min_select_chk #(
  parameter int NUM_BKT  = 64,
  parameter int CNT_W    = 4,
  localparam int IDX_W   = $clog2(NUM_BKT)
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          query_fire,
  input logic                          upd_inc,
  input logic                          upd_dec,
  input logic                          res_valid,
  input logic                          res_hit,
  input logic [IDX_W-1:0]              res_bucket,
  input logic [CNT_W-1:0]              res_count,
  input logic [NUM_BKT-1:0][CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  assert_result_due_R7: assert property (@(posedge clk) disable iff (!rst_n)
    query_fire |=> res_valid);
  assert_no_stray_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !query_fire |=> !res_valid);
  assert_miss_zeroed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_bucket == '0 && res_count == '0));
  assert_hit_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit) |-> (res_count != '0));
  assert_idle_keeps_counts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_inc || upd_dec) |=> $stable(cnt_q));

  for (genvar b = 0; b < NUM_BKT; b++) begin : g_cnt
    assert_sat_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q[b] == CNT_MAX) |=> (cnt_q[b] == CNT_MAX));
    assert_step_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((CNT_W+1)'(cnt_q[b]) + (CNT_W+1)'(1) >= (CNT_W+1)'($past(cnt_q[b]))) &&
      ((CNT_W+1)'(cnt_q[b]) <= (CNT_W+1)'($past(cnt_q[b])) + (CNT_W+1)'(1)));
  end
endmodule

bind cbf_min_select cbf_min_select_chk #(.NUM_BKT(NUM_BKT), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .query_fire (query_fire),
  .upd_inc    (upd_inc),
  .upd_dec    (upd_dec),
  .res_valid  (res_valid),
  .res_hit    (res_hit),
  .res_bucket (res_bucket),
  .res_count  (res_count),
  .cnt_q      (cnt_q)
);

// File: tb/sim_cbf_min_select.sv
`timescale 1ns/1ps
module sim_cbf_min_select;
  localparam int NB = 64;
  localparam int NH = 4;
  localparam int CW = 4;
  localparam int IW = 6;
  localparam int CMAX = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_valid = 1'b0;
  logic [1:0]    op_code = 2'b00;
  logic [NH*IW-1:0] op_idx = '0;
  logic          res_valid, res_hit;
  logic [IW-1:0] res_bucket;
  logic [CW-1:0] res_count;

  always #2 clk = ~clk;

  cbf_min_select #(.NUM_BKT(NB), .NUM_HASH(NH), .CNT_W(CW)) u0 (
    .clk, .rst_n, .op_valid, .op_code, .op_idx,
    .res_valid, .res_hit, .res_bucket, .res_count
  );

  int  model [NB];
  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // saturating model step, written independently of the design
  function automatic int model_step(input int cur, input int code);
    if (cur == CMAX) return cur;
    if (code == 1) return cur + 1;
    if (code == 2 && cur > 0) return cur - 1;
    return cur;
  endfunction

  task automatic run_op(input int code, input int idx [NH], input string req);
    bit seen [NB];
    int eb, ec, bi, bc;
    bit eh;
    eh = 1'b1; bi = idx[0]; bc = model[idx[0]];
    for (int j = 0; j < NH; j++) begin
      if (model[idx[j]] == 0) eh = 1'b0;
      if (model[idx[j]] < bc || (model[idx[j]] == bc && idx[j] < bi)) begin
        bc = model[idx[j]]; bi = idx[j];
      end
    end
    eb = eh ? bi : 0;
    ec = eh ? bc : 0;
    op_valid = 1'b1;
    op_code  = code[1:0];
    for (int j = 0; j < NH; j++) op_idx[j*IW +: IW] = idx[j][IW-1:0];
    @(negedge clk);
    op_valid = 1'b0;
    if (code == 0) begin
      chk(res_valid == 1'b1, "R7", "query strobe", int'(res_valid), 1);
      chk(res_hit == eh, req, "hit", int'(res_hit), int'(eh));
      chk(int'(res_bucket) == eb, req, "bucket", int'(res_bucket), eb);
      chk(int'(res_count) == ec, req, "count", int'(res_count), ec);
    end else begin
      chk(res_valid == 1'b0, (code == 3) ? "R8" : "R7", "no strobe", int'(res_valid), 0);
    end
    if (code == 1 || code == 2) begin
      for (int b = 0; b < NB; b++) seen[b] = 1'b0;
      for (int j = 0; j < NH; j++) begin
        if (!seen[idx[j]]) begin
          seen[idx[j]] = 1'b1;
          model[idx[j]] = model_step(model[idx[j]], code);
        end
      end
    end
  endtask

  task automatic op4(input int code, input int a, input int b, input int c, input int d, input string req);
    int v [NH];
    v[0] = a; v[1] = b; v[2] = c; v[3] = d;
    run_op(code, v, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run finished)");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1207));
    for (int b = 0; b < NB; b++) model[b] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(res_valid == 1'b0, "R1", "valid after reset", int'(res_valid), 0);
    chk(res_hit == 1'b0, "R1", "hit after reset", int'(res_hit), 0);
    op4(0, 0, 5, 33, 63, "R1");            // empty table: miss
    op4(1, 3, 3, 3, 3, "R2");              // duplicates merge
    op4(0, 3, 3, 3, 3, "R9");              // count 1 right away
    for (int i = 0; i < 20; i++) op4(1, 7, 7, 7, 7, "R5");
    op4(0, 7, 7, 7, 7, "R5");              // held at 15
    op4(2, 7, 7, 7, 7, "R5");
    op4(0, 7, 7, 7, 7, "R5");              // still 15 after delete
    op4(2, 10, 10, 10, 10, "R6");          // delete on empty
    op4(1, 10, 10, 10, 10, "R6");
    op4(0, 10, 10, 10, 10, "R6");          // exactly 1: no underflow
    op4(1, 20, 12, 40, 41, "R2");
    op4(1, 40, 41, 40, 41, "R2");
    op4(0, 20, 12, 40, 41, "R3");          // tie 20/12 at 1 -> 12
    op4(0, 41, 40, 41, 40, "R3");          // tie at 2 -> 40
    op4(0, 41, 40, 3, 12, "R3");           // mixed counts
    op4(0, 41, 40, 11, 12, "R4");          // 11 empty -> miss
    op4(3, 3, 3, 3, 3, "R8");              // reserved code
    op4(0, 3, 3, 3, 3, "R8");              // unchanged at 1
    op4(2, 40, 40, 41, 41, "R2");
    op4(0, 40, 41, 40, 41, "R2");          // both back to 1 -> 40
    for (int i = 0; i < 3000; i++) begin
      int v [NH];
      int code, rng;
      code = int'($urandom % 4);
      if (code == 3 && ($urandom % 3) != 0) code = 1;
      rng = (($urandom % 2) == 0) ? 8 : NB;
      for (int j = 0; j < NH; j++) v[j] = int'($urandom % rng);
      run_op(code, v, "R3");
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule